// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block turns the 16-bit address of an 8-bit CPU into a 24-bit physical address for a wider memory bus. The CPU space is cut into four 16KB windows. The lowest window always reaches the first 16KB page of ROM. The highest window always reaches the first 16KB page of RAM. Each of the two middle windows is steered by its own 8-bit bank register, which software loads with an I/O write.

A bank register holds a two-bit memory selector and a page number. The selector drives the two top address outputs. Its encoding makes those two outputs work as mutually exclusive ROM and RAM enables, and it leaves two more codes free for other memories. The page number becomes physical address bits 19:14.

A separate absolute-address unit can take over the bus through an override input. While the override is high, its 24-bit address passes straight to the output. The output is combinational in the CPU address, the bank registers and the override, so it is valid in the same bus cycle.

Top module: `bank_mapper`

## Requirements
- R1: A CPU address in 0x0000–0x3FFF gives phys[23:22]=2'b01 (ROM), phys[21:14]=0 and phys[13:0]=addr[13:0].
- R2: A CPU address in 0xC000–0xFFFF gives phys[23:22]=2'b10 (RAM), phys[21:14]=0 and phys[13:0]=addr[13:0].
- R3: A CPU address in 0x4000–0x7FFF uses the port-5 bank register, and 0x8000–0xBFFF uses the port-6 register. The output is phys[19:14]=reg[5:0], phys[21:20]=0 and phys[13:0]=addr[13:0].
- R4: Bank register bits 7:6 set phys[23:22] as follows: 00→01 (ROM), 01→10 (RAM), 10→00, 11→11.
- R5: A bank register loads the data byte when iorq_ni is low, wr_ni is low and addr[7:0] equals its port number. Address bits 15:8 are ignored. The new value reaches the output at the first clock edge that sees wr_ni high again.
- R6: A write to any other port, or a write with iorq_ni high, leaves both bank registers unchanged.
- R7: After reset both bank registers read 0x00, so both middle windows map to ROM page 0.
- R8: While abs_en_i is high, phys_addr_o equals abs_addr_i whatever the CPU address or the bank registers hold.
- R9: phys_addr_o follows a change of cpu_addr_i or abs_en_i with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the I/O strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus, sampled on port writes |
| iorq_ni | input | 1 | Active-low I/O request |
| wr_ni | input | 1 | Active-low write strobe |
| abs_en_i | input | 1 | Absolute-address override enable |
| abs_addr_i | input | 24 | Absolute address from the external unit |
| phys_addr_o | output | 24 | Physical address; bits 23:22 double as memory enables |

## Verification
A wrong bank register shows up as a wrong page or wrong enables on the first access to its window after the write commits. A register still stuck at its reset value also stays visible, because a write of a nonzero value never appears at the output. Decode faults in the fixed windows show in the same cycle as the address, as do faults in the selector table or the override. Comparing the output on every clock exposes a wrong write decode on the next window access. The same comparison catches a commit at the wrong edge, since it shows a one-cycle early or late change.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ROM  = 2'b00,
    SEL_RAM  = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIGH = 2'b11
  } mem_sel_e;

  // returns {A23, A22}
  function automatic logic [1:0] sel_to_cs(input mem_sel_e sel);
    unique case (sel)
      SEL_ROM:  sel_to_cs = 2'b01;
      SEL_RAM:  sel_to_cs = 2'b10;
      SEL_LOW:  sel_to_cs = 2'b00;
      default:  sel_to_cs = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/bank_port_reg.sv
module bank_port_reg #(
  parameter int unsigned MAP_W  = 8,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT = 8'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic [MAP_W-1:0]  data_i,
  output logic [MAP_W-1:0]  map_o
);
  logic [MAP_W-1:0] pend_q, map_q;
  logic             armed_q;
  logic             hit;

  assign hit   = !iorq_ni && !wr_ni && (port_i == PORT);
  assign map_o = map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      map_q   <= '0;
      armed_q <= 1'b0;
    end else if (hit) begin
      pend_q  <= data_i;
      armed_q <= 1'b1;
    end else if (armed_q && wr_ni) begin
      // strobe released: commit
      map_q   <= pend_q;
      armed_q <= 1'b0;
    end
  end

  assert_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr_ni) |=> (map_q == $past(pend_q)));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(armed_q && wr_ni) |=> $stable(map_q));
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bank_mapper_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned EXT_W  = 24,
  parameter int unsigned NWIN   = 2,
  localparam int unsigned WIN_W = ADDR_W - 2,
  localparam int unsigned MAP_W = PAGE_W + SEL_W,
  localparam int unsigned GAP_W = EXT_W - SEL_W - PAGE_W - WIN_W
) (
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [MAP_W-1:0]  map_i [NWIN],
  input  logic              abs_en_i,
  input  logic [EXT_W-1:0]  abs_addr_i,
  output logic [EXT_W-1:0]  phys_o
);
  mem_sel_e          sel;
  logic [PAGE_W-1:0] page;

  always_comb begin
    sel  = SEL_ROM;
    page = '0;
    unique case (cpu_addr_i[ADDR_W-1 -: 2])
      2'b00: sel = SEL_ROM;
      2'b11: sel = SEL_RAM;
      2'b01: begin
        sel  = mem_sel_e'(map_i[0][MAP_W-1 -: SEL_W]);
        page = map_i[0][PAGE_W-1:0];
      end
      default: begin
        sel  = mem_sel_e'(map_i[NWIN-1][MAP_W-1 -: SEL_W]);
        page = map_i[NWIN-1][PAGE_W-1:0];
      end
    endcase
  end

  assign phys_o = abs_en_i ? abs_addr_i
                           : {sel_to_cs(sel), {GAP_W{1'b0}}, page, cpu_addr_i[WIN_W-1:0]};
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned EXT_W     = 24,
  parameter int unsigned PORT_BASE = 5,
  localparam int unsigned NWIN   = 2,
  localparam int unsigned PORT_W = 8,
  localparam int unsigned WIN_W  = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  input  logic              abs_en_i,
  input  logic [EXT_W-1:0]  abs_addr_i,
  output logic [EXT_W-1:0]  phys_addr_o
);
  logic [DATA_W-1:0] map [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    bank_port_reg #(
      .MAP_W (DATA_W),
      .PORT_W(PORT_W),
      .PORT  (PORT_W'(PORT_BASE + w))
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .iorq_ni(iorq_ni),
      .wr_ni  (wr_ni),
      .port_i (cpu_addr_i[PORT_W-1:0]),
      .data_i (cpu_data_i),
      .map_o  (map[w])
    );
  end

  bank_decode #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W),
    .EXT_W (EXT_W),
    .NWIN  (NWIN)
  ) u_dec (
    .cpu_addr_i(cpu_addr_i),
    .map_i     (map),
    .abs_en_i  (abs_en_i),
    .abs_addr_i(abs_addr_i),
    .phys_o    (phys_addr_o)
  );

  assert_fixed_rom_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abs_en_i && cpu_addr_i[ADDR_W-1 -: 2] == 2'b00) |->
      (phys_addr_o[EXT_W-1 -: 2] == 2'b01 && phys_addr_o[WIN_W-1:0] == cpu_addr_i[WIN_W-1:0]));

  assert_fixed_ram_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abs_en_i && cpu_addr_i[ADDR_W-1 -: 2] == 2'b11) |->
      (phys_addr_o[EXT_W-1 -: 2] == 2'b10 && phys_addr_o[WIN_W-1:0] == cpu_addr_i[WIN_W-1:0]));

  assert_window_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abs_en_i && cpu_addr_i[ADDR_W-1 -: 2] == 2'b01) |->
      (phys_addr_o[WIN_W+PAGE_W-1:WIN_W] == map[0][PAGE_W-1:0]));

  assert_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abs_en_i |-> (phys_addr_o == abs_addr_i));
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        iorq_n = 1'b1, wr_n = 1'b1, abs_en = 1'b0;
  logic [23:0] abs_addr = '0;
  logic [23:0] phys;

  int checks = 0, errors = 0;
  int m5 = 0, m6 = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  bank_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .iorq_ni(iorq_n), .wr_ni(wr_n), .abs_en_i(abs_en), .abs_addr_i(abs_addr),
    .phys_addr_o(phys)
  );

  function automatic logic [23:0] model();
    int sel, page;
    logic [1:0] cs;
    if (abs_en) return abs_addr;
    case (addr[15:14])
      2'b00: begin sel = 0; page = 0; end
      2'b11: begin sel = 1; page = 0; end
      2'b01: begin sel = m5 / 64; page = m5 % 64; end
      default: begin sel = m6 / 64; page = m6 % 64; end
    endcase
    case (sel)
      0: cs = 2'b01;
      1: cs = 2'b10;
      2: cs = 2'b00;
      default: cs = 2'b11;
    endcase
    return {cs, 2'b00, 6'(page), addr[13:0]};
  endfunction

  task automatic check(string tag);
    logic [23:0] exp = model();
    checks++;
    if (phys !== exp) begin
      errors++;
      $display("FAIL %s: phys=%h expected=%h (addr=%h abs=%b)", tag, phys, exp, addr, abs_en);
    end
  endtask

  always @(negedge clk) if (cmp_on) check("clock compare R3");

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic iorq);
    @(posedge clk); #2;
    addr = a; data = d; iorq_n = iorq; wr_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 wr_n = 1'b1;
    @(posedge clk); #2;
    iorq_n = 1'b1;
    if (!iorq && a[7:0] == 8'd5) m5 = d;
    if (!iorq && a[7:0] == 8'd6) m6 = d;
  endtask

  task automatic look(input logic [15:0] a, string tag);
    addr = a; #1; check(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R7: reset state, both windows at ROM page 0
    look(16'h4123, "R7 window5 reset");
    look(16'h8abc, "R7 window6 reset");
    look(16'h0000, "R1 rom base");
    look(16'h3fff, "R1 rom top");
    look(16'hc000, "R2 ram base");
    look(16'hfedc, "R2 ram");
    cmp_on = 1'b1;
    // R5: port 5 write, upper address byte ignored
    io_write(16'hab05, 8'h07, 1'b0);
    look(16'h4001, "R5 port5 write");
    look(16'h8001, "R6 port6 untouched");
    io_write(16'h0006, 8'h7f, 1'b0);
    look(16'hbfff, "R4 sel01 RAM");
    look(16'h7fff, "R3 window5");
    io_write(16'h0005, 8'h95, 1'b0);
    look(16'h5555, "R4 sel10");
    io_write(16'h0006, 8'hc1, 1'b0);
    look(16'h9234, "R4 sel11");
    io_write(16'h0005, 8'h2a, 1'b0);
    look(16'h6000, "R4 sel00 ROM page");
    // R6: ignored writes
    io_write(16'h0007, 8'hff, 1'b0);
    look(16'h4000, "R6 port7 ignored w5");
    look(16'h8000, "R6 port7 ignored w6");
    io_write(16'h0005, 8'h33, 1'b1);
    look(16'h4abc, "R6 iorq high ignored");
    look(16'h0abc, "R1 rom with maps set");
    look(16'hcabc, "R2 ram with maps set");
    // R8 override
    @(posedge clk); #2;
    abs_addr = 24'hd3a5c1; abs_en = 1'b1;
    look(16'h4000, "R8 override window");
    look(16'hffff, "R8 override ram");
    abs_addr = 24'h000001;
    look(16'h0000, "R8 override rom");
    // R9: same-cycle response
    abs_en = 1'b0; #1; check("R9 override release");
    look(16'h8765, "R9 addr change");
    look(16'h2345, "R9 addr change rom");
    repeat (4) @(posedge clk);
    cmp_on = 1'b0;
    // R7: reset again
    #2 rst_n = 1'b0; m5 = 0; m6 = 0;
    look(16'h4444, "R7 reset w5");
    look(16'h8888, "R7 reset w6");
    rst_n = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule